// File: doc/BRIEF.md
# Plasma Subfield Drive Sequencer

This block times one display field of a plasma panel that keeps addressing and light emission in separate phases. One start strobe launches a fixed run of subfields. Each subfield first conditions every cell with a rising Y ramp and then a falling Y ramp, with the X bias held on during the falling ramp. It then writes the panel one scan line at a time. Last, it fires an alternating train of sustain pulses whose length sets that subfield's brightness weight.

Column data arrives one line at a time over a ready/valid handshake, already split into the bit-plane of the current subfield, and `sf_index` tells the source which plane to send. The block captures the accepted word, drives the scan pulse for that line and flags the cycle in which the captured word becomes valid. All outputs are digital strobes for the high-voltage pulse stages. Every phase length, the line count and the sustain scaling are parameters.

Top module: `pds_field_seq`

## Requirements
- R1: When `field_start` is sampled high while idle, `y_ramp_up` rises in the next cycle and stays high for exactly RAMP_UP_LEN cycles. Then `y_ramp_dn` and `x_bias` stay high together for exactly RAMP_DN_LEN cycles.
- R2: A field runs NUM_SF subfields in order, with `sf_index` going 0, 1, … NUM_SF-1. Each subfield does reset ramps, then addressing, then sustain.
- R3: Addressing visits lines 0 to LINES-1 in ascending order, one at a time. Each scan pulse (`scan_en`, with `scan_line` giving the line) lasts SCAN_LEN cycles. `col_latch` is high in the first scan cycle, and `col_q` holds that line's accepted word for the whole pulse.
- R4: `col_ready` is high only while a line waits for data. A transfer happens on a cycle with `col_ready` and `col_valid` both high, and that line's scan pulse starts in the next cycle.
- R5: A waiting cycle with `col_valid` low stalls the line and sets `underrun` from the next cycle. `underrun` then stays high until reset.
- R6: Subfield k (0-based) issues 2^(NUM_SF-1-k)·SUST_UNIT Y pulses and the same number of X pulses, so the heaviest subfield comes first.
- R7: Sustain always starts with a Y pulse and then alternates X, Y, X… The first Y pulse of a subfield lasts SUS_FIRST_LEN cycles and every other pulse lasts SUS_LEN cycles.
- R8: `x_sus` and `y_sus` are never high in the same cycle. Between two consecutive sustain pulses there are exactly DEAD_LEN cycles with neither high.
- R9: `field_done` is high for one cycle, in the cycle right after the last X pulse of the last subfield. The block is idle in the next cycle and accepts a new start.
- R10: A `field_start` sampled while a field is in progress has no effect on the sequence. It adds one to `overrun_cnt`, which saturates at all ones.
- R11: A cycle with `rst` high leaves every strobe low, `col_ready` low, `underrun` low, `overrun_cnt` zero and the block idle in the following cycle.
- R12: At most one of `y_ramp_up`, `y_ramp_dn`, `scan_en`, `y_sus`, `x_sus` and `col_ready` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| field_start | input | 1 | Launches a field when idle |
| col_valid | input | 1 | Column word for the next line is present |
| col_data | input | COLS | Column bit-plane word for the next line |
| col_ready | output | 1 | A line is waiting for its column word |
| col_q | output | COLS | Column word held for the current scan pulse |
| col_latch | output | 1 | First cycle of a scan pulse; `col_q` is new |
| scan_en | output | 1 | Scan pulse active |
| scan_line | output | $clog2(LINES) | Line selected by the scan pulse |
| y_ramp_up | output | 1 | Y rising-ramp interval |
| y_ramp_dn | output | 1 | Y falling-ramp interval |
| x_bias | output | 1 | X bias during the falling ramp |
| y_sus | output | 1 | Y sustain pulse |
| x_sus | output | 1 | X sustain pulse |
| sf_index | output | $clog2(NUM_SF) | Current subfield |
| field_done | output | 1 | One-cycle end-of-field pulse |
| underrun | output | 1 | Sticky column-data underrun |
| overrun_cnt | output | OVW | Saturating count of ignored starts |

## Verification
On every cycle the assertions check the local rules: phase exclusivity, the sustain strobes never overlapping, the Y-to-X turnaround, the ramp order, the handshake-to-scan step, the stickiness of the underrun flag, the overrun count moving only on a start, and the reset state. Some behaviour can only be shown by the bench scenarios, which compare each strobe run against a queue of expected runs. This covers whole-field properties: the binary-weighted pulse counts, the exact phase lengths and the stretched first pulse, the line order and captured data, and the placement of `field_done`. The same applies to ignored starts, a stalled line and reset in mid-field.

// File: rtl/pds_pkg.sv
package pds_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RUP,
      ST_RDN,
      ST_AWAIT,
      ST_ASCAN,
      ST_SON,
      ST_SGAP,
      ST_DONE
   } pds_state_e;

   function automatic int max_of5(int a, int b, int c, int d, int e);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      return m;
   endfunction

endpackage

// File: rtl/pds_seq_ctrl.sv
module pds_seq_ctrl
   import pds_pkg::*;
#(
   parameter int LINES         = 480,
   parameter int NUM_SF        = 8,
   parameter int SUST_UNIT     = 1,
   parameter int RAMP_UP_LEN   = 64,
   parameter int RAMP_DN_LEN   = 48,
   parameter int SCAN_LEN      = 4,
   parameter int SUS_LEN       = 6,
   parameter int SUS_FIRST_LEN = 12,
   parameter int DEAD_LEN      = 2,
   localparam int LW  = (LINES > 1) ? $clog2(LINES) : 1,
   localparam int SFW = (NUM_SF > 1) ? $clog2(NUM_SF) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             field_start,
   input  logic             col_valid,
   output pds_state_e       state,
   output logic [LW-1:0]    line,
   output logic [SFW-1:0]   sf,
   output logic             pulse_odd
);

   localparam int MAXL = max_of5(RAMP_UP_LEN, RAMP_DN_LEN, SCAN_LEN, SUS_FIRST_LEN,
                                 max_of5(SUS_LEN, DEAD_LEN, 1, 1, 1));
   localparam int TW   = $clog2(MAXL + 1);
   localparam int PW   = $clog2(2 * SUST_UNIT * (2 ** (NUM_SF - 1)) + 1);
   localparam logic [SFW-1:0] SF_LAST   = SFW'(NUM_SF - 1);
   localparam logic [LW-1:0]  LINE_LAST = LW'(LINES - 1);

   logic [TW-1:0]  tmr, plen;
   logic [PW-1:0]  pidx, ptot;
   logic [SFW-1:0] shamt;
   logic           last_tick;

   // pulse total for this subfield: two pulses per pair, weight halves per subfield
   assign shamt     = SF_LAST - sf;
   assign ptot      = PW'(2 * SUST_UNIT) << shamt;
   assign pulse_odd = pidx[0];

   always_comb begin
      unique case (state)
         ST_RUP:   plen = TW'(RAMP_UP_LEN);
         ST_RDN:   plen = TW'(RAMP_DN_LEN);
         ST_ASCAN: plen = TW'(SCAN_LEN);
         ST_SON:   plen = (pidx == '0) ? TW'(SUS_FIRST_LEN) : TW'(SUS_LEN);
         ST_SGAP:  plen = TW'(DEAD_LEN);
         default:  plen = TW'(1);
      endcase
   end

   assign last_tick = (tmr == plen - TW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         tmr   <= '0;
         line  <= '0;
         sf    <= '0;
         pidx  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               tmr <= '0;
               if (field_start) begin
                  state <= ST_RUP;
                  sf    <= '0;
               end
            end
            ST_RUP: begin
               if (last_tick) begin
                  tmr   <= '0;
                  state <= ST_RDN;
               end else tmr <= tmr + TW'(1);
            end
            ST_RDN: begin
               if (last_tick) begin
                  tmr   <= '0;
                  line  <= '0;
                  state <= ST_AWAIT;
               end else tmr <= tmr + TW'(1);
            end
            ST_AWAIT: begin
               tmr <= '0;
               if (col_valid) state <= ST_ASCAN;
            end
            ST_ASCAN: begin
               if (last_tick) begin
                  tmr <= '0;
                  if (line == LINE_LAST) begin
                     pidx  <= '0;
                     state <= ST_SON;
                  end else begin
                     line  <= line + LW'(1);
                     state <= ST_AWAIT;
                  end
               end else tmr <= tmr + TW'(1);
            end
            ST_SON: begin
               if (last_tick) begin
                  tmr <= '0;
                  if (pidx == ptot - PW'(1)) begin
                     if (sf == SF_LAST) state <= ST_DONE;
                     else begin
                        sf    <= sf + SFW'(1);
                        state <= ST_RUP;
                     end
                  end else state <= ST_SGAP;
               end else tmr <= tmr + TW'(1);
            end
            ST_SGAP: begin
               if (last_tick) begin
                  tmr   <= '0;
                  pidx  <= pidx + PW'(1);
                  state <= ST_SON;
               end else tmr <= tmr + TW'(1);
            end
            default: begin
               tmr   <= '0;
               state <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/pds_strobe_dec.sv
module pds_strobe_dec
   import pds_pkg::*;
#(
   parameter int LW = 9
) (
   input  pds_state_e      state,
   input  logic [LW-1:0]   line,
   input  logic            pulse_odd,
   output logic            y_ramp_up,
   output logic            y_ramp_dn,
   output logic            x_bias,
   output logic            scan_en,
   output logic [LW-1:0]   scan_line,
   output logic            y_sus,
   output logic            x_sus,
   output logic            col_ready,
   output logic            field_done
);

   assign y_ramp_up  = (state == ST_RUP);
   assign y_ramp_dn  = (state == ST_RDN);
   assign x_bias     = (state == ST_RDN);
   assign scan_en    = (state == ST_ASCAN);
   assign scan_line  = (state == ST_ASCAN) ? line : '0;
   // even pulse index is Y, so every train opens with Y
   assign y_sus      = (state == ST_SON) && !pulse_odd;
   assign x_sus      = (state == ST_SON) &&  pulse_odd;
   assign col_ready  = (state == ST_AWAIT);
   assign field_done = (state == ST_DONE);

endmodule

// File: rtl/pds_fault_track.sv
module pds_fault_track #(
   parameter int OVW = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            stall,
   input  logic            start_busy,
   output logic            underrun,
   output logic [OVW-1:0]  overrun_cnt
);

   always_ff @(posedge clk) begin
      if (rst) begin
         underrun    <= 1'b0;
         overrun_cnt <= '0;
      end else begin
         if (stall) underrun <= 1'b1;
         if (start_busy && (overrun_cnt != {OVW{1'b1}}))
            overrun_cnt <= overrun_cnt + OVW'(1);
      end
   end

endmodule

// File: rtl/pds_field_seq.sv
module pds_field_seq
   import pds_pkg::*;
#(
   parameter int LINES         = 480,
   parameter int NUM_SF        = 8,
   parameter int SUST_UNIT     = 1,
   parameter int RAMP_UP_LEN   = 64,
   parameter int RAMP_DN_LEN   = 48,
   parameter int SCAN_LEN      = 4,
   parameter int SUS_LEN       = 6,
   parameter int SUS_FIRST_LEN = 12,
   parameter int DEAD_LEN      = 2,
   parameter int COLS          = 32,
   parameter int OVW           = 8,
   localparam int LW  = (LINES > 1) ? $clog2(LINES) : 1,
   localparam int SFW = (NUM_SF > 1) ? $clog2(NUM_SF) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             field_start,
   input  logic             col_valid,
   input  logic [COLS-1:0]  col_data,
   output logic             col_ready,
   output logic [COLS-1:0]  col_q,
   output logic             col_latch,
   output logic             scan_en,
   output logic [LW-1:0]    scan_line,
   output logic             y_ramp_up,
   output logic             y_ramp_dn,
   output logic             x_bias,
   output logic             y_sus,
   output logic             x_sus,
   output logic [SFW-1:0]   sf_index,
   output logic             field_done,
   output logic             underrun,
   output logic [OVW-1:0]   overrun_cnt
);

   generate
      if (LINES < 1)                 begin : g_bad_lines  $error("LINES must be at least 1"); end
      if (NUM_SF < 1)                begin : g_bad_sf     $error("NUM_SF must be at least 1"); end
      if (SUST_UNIT < 1)             begin : g_bad_unit   $error("SUST_UNIT must be at least 1"); end
      if (DEAD_LEN < 1)              begin : g_bad_dead   $error("DEAD_LEN must be at least 1"); end
      if (SUS_FIRST_LEN <= SUS_LEN)  begin : g_bad_first  $error("first sustain pulse must be longer"); end
      if ((RAMP_UP_LEN < 1) || (RAMP_DN_LEN < 1) || (SCAN_LEN < 1) || (SUS_LEN < 1))
                                     begin : g_bad_len    $error("phase lengths must be at least 1"); end
      if (OVW < 1)                   begin : g_bad_ovw    $error("OVW must be at least 1"); end
   endgenerate

   pds_state_e     state;
   logic [LW-1:0]  line;
   logic           pulse_odd;
   logic           accept;

   pds_seq_ctrl #(
      .LINES(LINES), .NUM_SF(NUM_SF), .SUST_UNIT(SUST_UNIT),
      .RAMP_UP_LEN(RAMP_UP_LEN), .RAMP_DN_LEN(RAMP_DN_LEN), .SCAN_LEN(SCAN_LEN),
      .SUS_LEN(SUS_LEN), .SUS_FIRST_LEN(SUS_FIRST_LEN), .DEAD_LEN(DEAD_LEN)
   ) u_ctrl (
      .clk(clk), .rst(rst), .field_start(field_start), .col_valid(col_valid),
      .state(state), .line(line), .sf(sf_index), .pulse_odd(pulse_odd)
   );

   pds_strobe_dec #(.LW(LW)) u_dec (
      .state(state), .line(line), .pulse_odd(pulse_odd),
      .y_ramp_up(y_ramp_up), .y_ramp_dn(y_ramp_dn), .x_bias(x_bias),
      .scan_en(scan_en), .scan_line(scan_line), .y_sus(y_sus), .x_sus(x_sus),
      .col_ready(col_ready), .field_done(field_done)
   );

   pds_fault_track #(.OVW(OVW)) u_fault (
      .clk(clk), .rst(rst),
      .stall((state == ST_AWAIT) && !col_valid),
      .start_busy(field_start && (state != ST_IDLE)),
      .underrun(underrun), .overrun_cnt(overrun_cnt)
   );

   assign accept = (state == ST_AWAIT) && col_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         col_q     <= '0;
         col_latch <= 1'b0;
      end else begin
         col_latch <= accept;
         if (accept) col_q <= col_data;
      end
   end

endmodule

// File: rtl/pds_field_seq_chk.sv
module pds_field_seq_chk #(
   parameter int LINES = 480,
   parameter int COLS  = 32,
   parameter int OVW   = 8,
   parameter int LW    = 9
) (
   input logic             clk,
   input logic             rst,
   input logic             field_start,
   input logic             col_valid,
   input logic             col_ready,
   input logic [COLS-1:0]  col_q,
   input logic             col_latch,
   input logic             scan_en,
   input logic [LW-1:0]    scan_line,
   input logic             y_ramp_up,
   input logic             y_ramp_dn,
   input logic             x_bias,
   input logic             y_sus,
   input logic             x_sus,
   input logic             field_done,
   input logic             underrun,
   input logic [OVW-1:0]   overrun_cnt
);

   p_ramp_order_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(y_ramp_dn) |-> $past(y_ramp_up));

   p_bias_in_fall_r1: assert property (@(posedge clk) disable iff (rst)
      y_ramp_dn |-> x_bias);

   p_latch_in_scan_r3: assert property (@(posedge clk) disable iff (rst)
      col_latch |-> scan_en);

   p_line_range_r3: assert property (@(posedge clk) disable iff (rst)
      scan_en |-> (int'(scan_line) < LINES));

   p_col_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (scan_en && !col_latch) |-> $stable(col_q));

   p_hs_to_scan_r4: assert property (@(posedge clk) disable iff (rst)
      (col_ready && col_valid) |=> (scan_en && col_latch));

   p_underrun_set_r5: assert property (@(posedge clk) disable iff (rst)
      (col_ready && !col_valid) |=> underrun);

   p_underrun_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      underrun |=> underrun);

   p_sus_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(x_sus && y_sus));

   p_y_to_x_gap_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(y_sus) |-> !x_sus);

   p_x_to_y_gap_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(x_sus) |-> !y_sus);

   p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
      field_done |=> !field_done);

   p_ovr_only_on_start_r10: assert property (@(posedge clk) disable iff (rst)
      !field_start |=> $stable(overrun_cnt));

   p_reset_state_r11: assert property (@(posedge clk)
      rst |=> (!y_ramp_up && !y_ramp_dn && !x_bias && !scan_en && !y_sus && !x_sus &&
               !col_ready && !col_latch && !field_done && !underrun && (overrun_cnt == '0)));

   p_phase_onehot_r12: assert property (@(posedge clk) disable iff (rst)
      $onehot0({y_ramp_up, y_ramp_dn, scan_en, y_sus, x_sus, col_ready}));

endmodule

bind pds_field_seq pds_field_seq_chk #(
   .LINES(LINES), .COLS(COLS), .OVW(OVW), .LW(LW)
) u_chk (
   .clk(clk), .rst(rst), .field_start(field_start), .col_valid(col_valid),
   .col_ready(col_ready), .col_q(col_q), .col_latch(col_latch), .scan_en(scan_en),
   .scan_line(scan_line), .y_ramp_up(y_ramp_up), .y_ramp_dn(y_ramp_dn), .x_bias(x_bias),
   .y_sus(y_sus), .x_sus(x_sus), .field_done(field_done), .underrun(underrun),
   .overrun_cnt(overrun_cnt)
);

// File: tb/pds_field_seq_tb.sv
module pds_field_seq_tb;

   localparam int LINES  = 3;
   localparam int NSF    = 8;
   localparam int T      = 2;
   localparam int RU     = 3;
   localparam int RD     = 2;
   localparam int SCN    = 2;
   localparam int SUS    = 2;
   localparam int FIRST  = 4;
   localparam int DEAD   = 1;
   localparam int COLS   = 8;
   localparam int OVW    = 4;
   localparam int LW     = $clog2(LINES);
   localparam int SFW    = $clog2(NSF);

   logic clk = 1'b0;
   logic rst, field_start, col_valid;
   logic [COLS-1:0] col_data, col_q;
   logic col_ready, col_latch, scan_en, y_ramp_up, y_ramp_dn, x_bias, y_sus, x_sus;
   logic field_done, underrun;
   logic [LW-1:0]  scan_line;
   logic [SFW-1:0] sf_index;
   logic [OVW-1:0] overrun_cnt;

   always #5 clk = ~clk;

   pds_field_seq #(
      .LINES(LINES), .NUM_SF(NSF), .SUST_UNIT(T), .RAMP_UP_LEN(RU), .RAMP_DN_LEN(RD),
      .SCAN_LEN(SCN), .SUS_LEN(SUS), .SUS_FIRST_LEN(FIRST), .DEAD_LEN(DEAD),
      .COLS(COLS), .OVW(OVW)
   ) u_dut (
      .clk(clk), .rst(rst), .field_start(field_start), .col_valid(col_valid),
      .col_data(col_data), .col_ready(col_ready), .col_q(col_q), .col_latch(col_latch),
      .scan_en(scan_en), .scan_line(scan_line), .y_ramp_up(y_ramp_up), .y_ramp_dn(y_ramp_dn),
      .x_bias(x_bias), .y_sus(y_sus), .x_sus(x_sus), .sf_index(sf_index),
      .field_done(field_done), .underrun(underrun), .overrun_cnt(overrun_cnt)
   );

   typedef struct packed {
      int code; int arg; int sfi; int len; int data; bit last;
   } ev_t;

   ev_t exp_q[$];
   int  total = 0, bad = 0, done_seen = 0;
   bit  mon_en = 1'b0, stall_en = 1'b0, finished = 1'b0;

   function automatic logic [COLS-1:0] colpat(int s, int l);
      return COLS'((s * 37 + l * 11 + 5) & 255);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // driver: expected strobe runs of one whole field (R1, R2, R3, R6, R7, R9)
   task automatic push_field();
      ev_t e;
      for (int s = 0; s < NSF; s++) begin
         e = '{code: 1, arg: 0, sfi: s, len: RU, data: 0, last: 1'b0}; exp_q.push_back(e);
         e = '{code: 2, arg: 0, sfi: s, len: RD, data: 0, last: 1'b0}; exp_q.push_back(e);
         for (int l = 0; l < LINES; l++) begin
            e = '{code: 3, arg: l, sfi: s, len: SCN, data: int'(colpat(s, l)), last: 1'b0};
            exp_q.push_back(e);
         end
         for (int p = 0; p < 2 * T * (1 << (NSF - 1 - s)); p++) begin
            e.code = (p % 2 == 0) ? 4 : 5;
            e.arg  = 0;
            e.sfi  = s;
            e.len  = (p == 0) ? FIRST : SUS;
            e.data = 0;
            e.last = (s == NSF - 1) && (p == 2 * T * (1 << (NSF - 1 - s)) - 1);
            exp_q.push_back(e);
         end
      end
   endtask

   // column source: one word per line, optional stall on one line
   initial begin
      int idx, stall_cnt, li;
      bit hs;
      idx = 0; stall_cnt = 0; hs = 1'b0;
      col_valid = 1'b0; col_data = '0;
      forever begin
         @(negedge clk);
         if (hs) idx++;
         li = idx % (NSF * LINES);
         if (stall_en && li == 4 && stall_cnt < 5) begin
            col_valid = 1'b0;
            stall_cnt++;
         end else col_valid = 1'b1;
         col_data = colpat((li / LINES) % NSF, li % LINES);
         hs = col_ready && col_valid;
      end
   end

   // monitor: split outputs into strobe runs and compare with the queue
   initial begin
      int c, pc, rl, pa, psf, pdat, lastnz;
      bit bias_bad, latch_ok;
      ev_t e;
      pc = 0; rl = 0; pa = 0; psf = 0; pdat = 0; lastnz = 0; bias_bad = 0; latch_ok = 0;
      forever begin
         @(negedge clk);
         if (rst || !mon_en) begin
            pc = 0; rl = 0; lastnz = 0; bias_bad = 0;
         end else begin
            c = y_ramp_up ? 1 : y_ramp_dn ? 2 : scan_en ? 3 : y_sus ? 4 : x_sus ? 5 : 0;
            if (x_bias != y_ramp_dn) bias_bad = 1'b1;
            if (field_done) done_seen++;
            if (c == pc) rl++;
            else begin
               if (pc == 0 && (c == 4 || c == 5) && (lastnz == 4 || lastnz == 5))
                  chk(rl == DEAD && c != lastnz, "R8", "sustain gap length", rl, DEAD);
               if (pc != 0) begin
                  if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected strobe run code", pc, 0);
                  else begin
                     e = exp_q.pop_front();
                     chk(e.code == pc && e.len == rl && e.sfi == psf &&
                         (pc != 3 || (e.arg == pa && e.data == pdat && latch_ok)) &&
                         (pc != 2 || !bias_bad),
                         (pc <= 2) ? "R1" : (pc == 3) ? "R3" : "R7",
                         $sformatf("run code %0d/%0d sf %0d/%0d line %0d/%0d data %0d/%0d len",
                                   pc, e.code, psf, e.sfi, pa, e.arg, pdat, e.data), rl, e.len);
                     if (e.last) chk(field_done == 1'b1, "R9", "field_done after last X", field_done, 1);
                  end
                  lastnz = pc;
               end
               pc = c; rl = 1; pa = int'(scan_line); psf = int'(sf_index);
               pdat = int'(col_q); latch_ok = col_latch; bias_bad = (x_bias != y_ramp_dn);
            end
         end
      end
   end

   task automatic pulse_start();
      field_start = 1'b1;
      @(negedge clk);
      field_start = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!field_done);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      rst = 1'b1; field_start = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11: reset state
      chk(!(y_ramp_up || y_ramp_dn || x_bias || scan_en || y_sus || x_sus || col_ready ||
            col_latch || field_done), "R11", "strobes after reset", 1, 0);
      chk(underrun == 1'b0, "R11", "underrun after reset", underrun, 0);
      chk(overrun_cnt == '0, "R11", "overrun after reset", int'(overrun_cnt), 0);

      // field 1: full rate data, two ignored starts (R10)
      mon_en = 1'b1;
      push_field();
      pulse_start();
      chk(y_ramp_up == 1'b1, "R1", "ramp up one cycle after start", y_ramp_up, 1);
      repeat (100) @(negedge clk);
      pulse_start();
      repeat (400) @(negedge clk);
      pulse_start();
      wait_done();
      @(negedge clk);
      chk(field_done == 1'b0, "R9", "field_done single cycle", field_done, 0);
      chk(y_ramp_up == 1'b0, "R9", "idle after done", y_ramp_up, 0);
      chk(exp_q.size() == 0, "R6", "runs left after field 1", exp_q.size(), 0);
      chk(overrun_cnt == OVW'(2), "R10", "overrun count", int'(overrun_cnt), 2);
      chk(underrun == 1'b0, "R5", "no underrun at full rate", underrun, 0);
      chk(done_seen == 1, "R9", "done pulses field 1", done_seen, 1);

      // field 2: one stalled line (R4, R5)
      stall_en = 1'b1;
      push_field();
      pulse_start();
      wait_done();
      @(negedge clk);
      chk(underrun == 1'b1, "R5", "underrun after stall", underrun, 1);
      chk(exp_q.size() == 0, "R4", "runs left after stalled field", exp_q.size(), 0);
      chk(overrun_cnt == OVW'(2), "R10", "overrun unchanged", int'(overrun_cnt), 2);
      chk(done_seen == 2, "R9", "done pulses field 2", done_seen, 2);

      // field 3: reset in mid-field (R11), then restart (R1, R2)
      mon_en = 1'b0;
      pulse_start();
      chk(y_ramp_up == 1'b1, "R1", "ramp up field 3", y_ramp_up, 1);
      chk(sf_index == '0, "R2", "first subfield index", int'(sf_index), 0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!(y_ramp_up || y_ramp_dn || x_bias || scan_en || y_sus || x_sus || col_ready),
          "R11", "strobes after mid-field reset", y_ramp_up, 0);
      chk(underrun == 1'b0, "R11", "underrun cleared", underrun, 1'b0);
      chk(overrun_cnt == '0, "R11", "overrun cleared", int'(overrun_cnt), 0);
      @(negedge clk);
      pulse_start();
      chk(y_ramp_up == 1'b1, "R1", "restart after reset", y_ramp_up, 1);
      repeat (RU) @(negedge clk);
      chk(y_ramp_dn && x_bias && !y_ramp_up, "R12", "falling ramp after rising ramp",
          int'({y_ramp_dn, x_bias, y_ramp_up}), 6);
      summary();
   end

endmodule